// File: doc/BRIEF.md
# Ring Message Send and Receive Unit

This unit sits on one stop of a slotted ring and passes variable-length messages between cores. Each clock cycle one slot arrives on the ring input and, one cycle later, leaves on the ring output, either unchanged or rewritten. To send, the CPU pushes body words into a local send buffer and then issues a go command with the destination core, the message type and the body length. The unit claims free (Null) slots for a header slot and then one slot per body word.

On the receive side, the unit watches for Message slots addressed to its own core. If the receive FIFO has room for the whole message, it stores the header word and the body words and frees each slot by turning it into a Null slot. A message with an empty body is not stored: its header word goes to a debug output for one cycle. The CPU polls the receive FIFO through an empty flag, a head-word output and a pop strobe.

Top module: `ring_msg_unit`

## Requirements
- R1: Slots that are not taken are copied to the ring output one cycle after they arrive, with kind, destination and data unchanged. This applies to kind codes 2 and 3, Message slots (kind 1) for other cores, and Null slots (kind 0) that the sender does not claim.
- R2: A header slot has kind 1, the requested destination, and data {18'b0, src[13:10], type[9:6], length[5:0]}, where src is the CORE_ID parameter.
- R3: The sender claims only incoming Null slots. After the header, it fills exactly length further Null slots with the buffered words, in the order they were pushed. Slots of any other kind that arrive in between are forwarded.
- R4: tx_busy rises in the cycle after an accepted go and falls when the last slot of the message appears on the ring output. A go while tx_busy is high is ignored. The header is held back until the send buffer holds at least length words.
- R5: A kind-1 slot whose destination equals CORE_ID opens a message when the unit is not inside one. If the message has a non-zero length and free FIFO space is at least length+1, the header and the following length body words enter the FIFO in arrival order. Each of those slots leaves as a Null slot with zero destination and zero data.
- R6: A header addressed to this core with length 0 produces dbg_valid for exactly one cycle, in the same cycle its slot leaves as Null, with dbg_word equal to the header data. The FIFO is not changed.
- R7: If free FIFO space is less than length+1 at the header slot, the header and its body slots are forwarded unchanged and nothing is queued. A message that fills the FIFO exactly is accepted.
- R8: rx_empty is high when the FIFO holds no word. rx_word shows the oldest word. rx_pop removes it, and rx_pop has no effect when the FIFO is empty.
- R9: While reset is high, the ring output carries Null slots, rx_empty is high, and tx_busy and dbg_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_in_kind | input | 2 | Incoming slot kind (0 Null, 1 Message, 2/3 other) |
| ring_in_dest | input | 4 | Incoming slot destination core |
| ring_in_data | input | 32 | Incoming slot data word |
| ring_out_kind | output | 2 | Outgoing slot kind |
| ring_out_dest | output | 4 | Outgoing slot destination core |
| ring_out_data | output | 32 | Outgoing slot data word |
| tx_push | input | 1 | Push tx_word into the send buffer |
| tx_word | input | 32 | Body word to buffer |
| tx_go | input | 1 | Start sending a message |
| tx_dest | input | 4 | Destination core of the message |
| tx_type | input | 4 | Message type field |
| tx_len | input | 6 | Body length in words |
| tx_busy | output | 1 | A send is in progress |
| rx_pop | input | 1 | Remove the head word of the receive FIFO |
| rx_word | output | 32 | Head word of the receive FIFO |
| rx_empty | output | 1 | Receive FIFO holds no word |
| dbg_valid | output | 1 | A zero-length message arrived |
| dbg_word | output | 32 | Header word of that message |

## Verification
The properties assume that a slot is presented every cycle and that two messages addressed to this core never overlap on the ring. The receiver treats the first slot for this core after a complete message as a header, so that first slot must really be a header. The stimulus always sends a header followed directly by its own body slots before any other message for this core appears. Other slot kinds and traffic for other cores are placed only between or inside messages.

// File: rtl/ring_msg_pkg.sv
package ring_msg_pkg;

    localparam int DEST_W = 4;
    localparam int DATA_W = 32;
    localparam int TYPE_W = 4;
    localparam int SRC_W  = 4;
    localparam int LEN_W  = 6;
    localparam int HDR_W  = SRC_W + TYPE_W + LEN_W;

    typedef enum logic [1:0] {
        SLOT_NULL  = 2'd0,
        SLOT_MSG   = 2'd1,
        SLOT_OTH_A = 2'd2,
        SLOT_OTH_B = 2'd3
    } slot_kind_e;

    typedef struct packed {
        slot_kind_e          kind;
        logic [DEST_W-1:0]   dest;
        logic [DATA_W-1:0]   data;
    } slot_t;

    localparam slot_t EMPTY_SLOT = '{kind: SLOT_NULL, dest: '0, data: '0};

    typedef enum logic [1:0] {TX_IDLE, TX_HDR, TX_BODY} tx_state_e;
    typedef enum logic [1:0] {RX_IDLE, RX_TAKE, RX_PASS} rx_state_e;

    function automatic logic [DATA_W-1:0] pack_hdr(input logic [SRC_W-1:0]  src,
                                                   input logic [TYPE_W-1:0] typ,
                                                   input logic [LEN_W-1:0]  len);
        return {{(DATA_W-HDR_W){1'b0}}, src, typ, len};
    endfunction

    function automatic logic [LEN_W-1:0] hdr_len(input logic [DATA_W-1:0] w);
        return w[LEN_W-1:0];
    endfunction

endpackage

// File: rtl/ring_msg_fifo.sv
module ring_msg_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic [CW-1:0]    level
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic [CW-1:0]    cnt;
    logic             full, do_push, do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];
    assign level   = cnt;

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/ring_msg_tx.sv
module ring_msg_tx
    import ring_msg_pkg::*;
#(
    parameter int CORE_ID   = 0,
    parameter int BUF_DEPTH = 64,
    localparam int CW = $clog2(BUF_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  slot_t             slot_in,
    input  logic              push,
    input  logic [DATA_W-1:0] word,
    input  logic              go,
    input  logic [DEST_W-1:0] dest,
    input  logic [TYPE_W-1:0] mtype,
    input  logic [LEN_W-1:0]  len,
    output logic              busy,
    output logic              take,
    output slot_t             slot_new
);
    tx_state_e         state;
    logic [DEST_W-1:0] r_dest;
    logic [TYPE_W-1:0] r_type;
    logic [LEN_W-1:0]  r_len, rem;
    logic              buf_pop, buf_empty;
    logic [DATA_W-1:0] buf_head;
    logic [CW-1:0]     buf_level;
    logic              slot_free;

    ring_msg_fifo #(.WIDTH(DATA_W), .DEPTH(BUF_DEPTH)) u_buf (
        .clk(clk), .rst(rst), .push(push), .din(word), .pop(buf_pop),
        .dout(buf_head), .empty(buf_empty), .level(buf_level)
    );

    assign slot_free = (slot_in.kind == SLOT_NULL);
    assign busy      = (state != TX_IDLE);

    always_comb begin
        take     = 1'b0;
        buf_pop  = 1'b0;
        slot_new = slot_in;
        case (state)
            TX_HDR: if (slot_free && buf_level >= CW'(r_len)) begin
                take     = 1'b1;
                slot_new = '{kind: SLOT_MSG, dest: r_dest,
                             data: pack_hdr(SRC_W'(CORE_ID), r_type, r_len)};
            end
            TX_BODY: if (slot_free && !buf_empty) begin
                take     = 1'b1;
                buf_pop  = 1'b1;
                slot_new = '{kind: SLOT_MSG, dest: r_dest, data: buf_head};
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= TX_IDLE;
            r_dest <= '0;
            r_type <= '0;
            r_len  <= '0;
            rem    <= '0;
        end else begin
            case (state)
                TX_IDLE: if (go) begin
                    r_dest <= dest;
                    r_type <= mtype;
                    r_len  <= len;
                    state  <= TX_HDR;
                end
                TX_HDR: if (take) begin
                    rem   <= r_len;
                    state <= (r_len == '0) ? TX_IDLE : TX_BODY;
                end
                TX_BODY: if (take) begin
                    rem <= rem - 1'b1;
                    if (rem == LEN_W'(1)) state <= TX_IDLE;
                end
                default: state <= TX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ring_msg_rx.sv
module ring_msg_rx
    import ring_msg_pkg::*;
#(
    parameter int CORE_ID  = 0,
    parameter int FIFO_DEPTH = 1024,
    localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  slot_t         slot_in,
    input  logic [CW-1:0] fifo_level,
    output logic          consume,
    output logic          push,
    output logic          dbg_fire
);
    rx_state_e        state;
    logic [LEN_W-1:0] rem, len;
    logic             mine, room_ok;

    assign mine    = (slot_in.kind == SLOT_MSG) && (slot_in.dest == DEST_W'(CORE_ID));
    assign len     = hdr_len(slot_in.data);
    assign room_ok = (FIFO_DEPTH - int'(fifo_level)) > int'(len);

    always_comb begin
        consume  = 1'b0;
        push     = 1'b0;
        dbg_fire = 1'b0;
        if (mine) begin
            case (state)
                RX_IDLE: begin
                    if (len == '0) begin
                        consume  = 1'b1;
                        dbg_fire = 1'b1;
                    end else if (room_ok) begin
                        consume = 1'b1;
                        push    = 1'b1;
                    end
                end
                RX_TAKE: begin
                    consume = 1'b1;
                    push    = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RX_IDLE;
            rem   <= '0;
        end else if (mine) begin
            case (state)
                RX_IDLE: if (len != '0) begin
                    rem   <= len;
                    state <= room_ok ? RX_TAKE : RX_PASS;
                end
                default: begin
                    rem <= rem - 1'b1;
                    if (rem == LEN_W'(1)) state <= RX_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/ring_msg_unit.sv
module ring_msg_unit
    import ring_msg_pkg::*;
#(
    parameter int CORE_ID  = 1,
    parameter int RX_DEPTH = 1024,
    parameter int TX_DEPTH = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  ring_in_kind,
    input  logic [3:0]  ring_in_dest,
    input  logic [31:0] ring_in_data,
    output logic [1:0]  ring_out_kind,
    output logic [3:0]  ring_out_dest,
    output logic [31:0] ring_out_data,
    input  logic        tx_push,
    input  logic [31:0] tx_word,
    input  logic        tx_go,
    input  logic [3:0]  tx_dest,
    input  logic [3:0]  tx_type,
    input  logic [5:0]  tx_len,
    output logic        tx_busy,
    input  logic        rx_pop,
    output logic [31:0] rx_word,
    output logic        rx_empty,
    output logic        dbg_valid,
    output logic [31:0] dbg_word
);
    localparam int RCW = $clog2(RX_DEPTH + 1);

    slot_t          slot_in, tx_slot, out_q;
    logic           tx_take, rx_consume, rx_push, rx_dbg;
    logic [RCW-1:0] rx_level;

    assign slot_in = '{kind: slot_kind_e'(ring_in_kind), dest: ring_in_dest, data: ring_in_data};

    ring_msg_tx #(.CORE_ID(CORE_ID), .BUF_DEPTH(TX_DEPTH)) u_tx (
        .clk(clk), .rst(rst), .slot_in(slot_in), .push(tx_push), .word(tx_word),
        .go(tx_go), .dest(tx_dest), .mtype(tx_type), .len(tx_len),
        .busy(tx_busy), .take(tx_take), .slot_new(tx_slot)
    );

    ring_msg_rx #(.CORE_ID(CORE_ID), .FIFO_DEPTH(RX_DEPTH)) u_rx (
        .clk(clk), .rst(rst), .slot_in(slot_in), .fifo_level(rx_level),
        .consume(rx_consume), .push(rx_push), .dbg_fire(rx_dbg)
    );

    ring_msg_fifo #(.WIDTH(DATA_W), .DEPTH(RX_DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .push(rx_push), .din(ring_in_data), .pop(rx_pop),
        .dout(rx_word), .empty(rx_empty), .level(rx_level)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q     <= EMPTY_SLOT;
            dbg_valid <= 1'b0;
            dbg_word  <= '0;
        end else begin
            if (rx_consume)   out_q <= EMPTY_SLOT;
            else if (tx_take) out_q <= tx_slot;
            else              out_q <= slot_in;
            dbg_valid <= rx_dbg;
            if (rx_dbg) dbg_word <= ring_in_data;
        end
    end

    assign ring_out_kind = out_q.kind;
    assign ring_out_dest = out_q.dest;
    assign ring_out_data = out_q.data;
endmodule

// File: rtl/ring_msg_chk.sv
module ring_msg_chk #(
    parameter int CORE_ID = 1
) (
    input logic        clk,
    input logic        rst,
    input logic [1:0]  ring_in_kind,
    input logic [3:0]  ring_in_dest,
    input logic [31:0] ring_in_data,
    input logic [1:0]  ring_out_kind,
    input logic [3:0]  ring_out_dest,
    input logic [31:0] ring_out_data,
    input logic        tx_busy,
    input logic        dbg_valid,
    input logic [31:0] dbg_word
);
    logic [37:0] in_slot, out_slot;
    logic        for_me;
    assign in_slot  = {ring_in_kind, ring_in_dest, ring_in_data};
    assign out_slot = {ring_out_kind, ring_out_dest, ring_out_data};
    assign for_me   = (ring_in_kind == 2'd1) && (ring_in_dest == 4'(CORE_ID));

    p_fwd_untouched_r1: assert property (@(posedge clk) disable iff (rst)
        (ring_in_kind != 2'd0 && !for_me) |=> (out_slot == $past(in_slot)));

    p_own_slot_freed_or_kept_r5: assert property (@(posedge clk) disable iff (rst)
        for_me |=> (out_slot == 38'd0) || (out_slot == $past(in_slot)));

    p_dbg_from_empty_msg_r6: assert property (@(posedge clk) disable iff (rst)
        dbg_valid |-> ($past(for_me) && $past(ring_in_data[5:0]) == 6'd0
                       && dbg_word == $past(ring_in_data) && ring_out_kind == 2'd0));

    p_last_slot_on_ring_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_busy) |-> (ring_out_kind == 2'd1));
endmodule

bind ring_msg_unit ring_msg_chk #(.CORE_ID(CORE_ID)) u_chk (
    .clk(clk), .rst(rst),
    .ring_in_kind(ring_in_kind), .ring_in_dest(ring_in_dest), .ring_in_data(ring_in_data),
    .ring_out_kind(ring_out_kind), .ring_out_dest(ring_out_dest), .ring_out_data(ring_out_data),
    .tx_busy(tx_busy), .dbg_valid(dbg_valid), .dbg_word(dbg_word)
);

// File: tb/sim_ring_msg_unit.sv
module sim_ring_msg_unit;
    localparam int ID    = 5;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  ring_in_kind = '0;
    logic [3:0]  ring_in_dest = '0;
    logic [31:0] ring_in_data = '0;
    logic [1:0]  ring_out_kind;
    logic [3:0]  ring_out_dest;
    logic [31:0] ring_out_data;
    logic        tx_push = 1'b0, tx_go = 1'b0, rx_pop = 1'b0;
    logic [31:0] tx_word = '0;
    logic [3:0]  tx_dest = '0, tx_type = '0;
    logic [5:0]  tx_len = '0;
    logic        tx_busy, rx_empty, dbg_valid;
    logic [31:0] rx_word, dbg_word;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    ring_msg_unit #(.CORE_ID(ID), .RX_DEPTH(DEPTH), .TX_DEPTH(64)) u0 (.*);

    // stimulus slot {kind,dest,data} and the slot expected one cycle later
    localparam logic [75:0] FWD_TAB [6] = '{
        {38'({2'd0, 4'd0, 32'h0}),         38'({2'd0, 4'd0, 32'h0})},
        {38'({2'd2, 4'd5, 32'h1234_5678}), 38'({2'd2, 4'd5, 32'h1234_5678})},
        {38'({2'd1, 4'd3, 32'hDEAD_BEEF}), 38'({2'd1, 4'd3, 32'hDEAD_BEEF})},
        {38'({2'd3, 4'd5, 32'h0000_0001}), 38'({2'd3, 4'd5, 32'h0000_0001})},
        {38'({2'd1, 4'd0, 32'hFFFF_FFFF}), 38'({2'd1, 4'd0, 32'hFFFF_FFFF})},
        {38'({2'd2, 4'd0, 32'h0000_0000}), 38'({2'd2, 4'd0, 32'h0000_0000})}
    };

    function automatic logic [31:0] hdr(input int src, input int typ, input int len);
        return (32'(src) << 10) | (32'(typ) << 6) | 32'(len);
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic [1:0] k, input logic [3:0] d, input logic [31:0] w);
        ring_in_kind = k;
        ring_in_dest = d;
        ring_in_data = w;
        @(posedge clk);
        #1;
        tx_push = 1'b0;
        tx_go   = 1'b0;
        rx_pop  = 1'b0;
    endtask

    function automatic logic [63:0] outs();
        return 64'({ring_out_kind, ring_out_dest, ring_out_data});
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R9 reset state
        chk("R9 ring_out", outs(), 64'd0);
        chk("R9 rx_empty", 64'(rx_empty), 64'd1);
        chk("R9 tx_busy", 64'(tx_busy), 64'd0);
        chk("R9 dbg_valid", 64'(dbg_valid), 64'd0);
        rst = 1'b0;

        // R1 forwarding table
        for (int i = 0; i < 6; i++) begin
            step(FWD_TAB[i][75:74], FWD_TAB[i][73:70], FWD_TAB[i][69:38]);
            chk("R1 forward", outs(), 64'(FWD_TAB[i][37:0]));
        end

        // R2 R3 R4 send of three words
        tx_push = 1'b1; tx_word = 32'hA0A0_0001; step(2'd0, 4'd0, 32'h0);
        chk("R1 idle null", outs(), 64'd0);
        tx_push = 1'b1; tx_word = 32'hB0B0_0002; step(2'd2, 4'd1, 32'h11);
        tx_push = 1'b1; tx_word = 32'hC0C0_0003; step(2'd2, 4'd1, 32'h12);
        tx_go = 1'b1; tx_dest = 4'd9; tx_type = 4'd2; tx_len = 6'd3;
        step(2'd2, 4'd7, 32'h77);
        chk("R4 busy after go", 64'(tx_busy), 64'd1);
        chk("R3 other slot not taken", outs(), 64'({2'd2, 4'd7, 32'h77}));
        tx_go = 1'b1; tx_len = 6'd1; tx_dest = 4'd4;
        step(2'd3, 4'd2, 32'h88);
        chk("R3 other slot forwarded", outs(), 64'({2'd3, 4'd2, 32'h88}));
        step(2'd0, 4'd0, 32'h0);
        chk("R2 header slot", outs(), 64'({2'd1, 4'd9, hdr(ID, 2, 3)}));
        step(2'd0, 4'd0, 32'h0);
        chk("R3 body word 1", outs(), 64'({2'd1, 4'd9, 32'hA0A0_0001}));
        step(2'd1, 4'd3, 32'h55);
        chk("R3 busy message forwarded", outs(), 64'({2'd1, 4'd3, 32'h55}));
        step(2'd0, 4'd0, 32'h0);
        chk("R3 body word 2", outs(), 64'({2'd1, 4'd9, 32'hB0B0_0002}));
        step(2'd0, 4'd0, 32'h0);
        chk("R3 body word 3", outs(), 64'({2'd1, 4'd9, 32'hC0C0_0003}));
        chk("R4 busy falls", 64'(tx_busy), 64'd0);
        step(2'd0, 4'd0, 32'h0);
        chk("R4 go while busy ignored", outs(), 64'd0);

        // R4 header waits for buffered words
        tx_push = 1'b1; tx_word = 32'hD0D0_0004;
        tx_go = 1'b1; tx_dest = 4'd2; tx_type = 4'd1; tx_len = 6'd2;
        step(2'd0, 4'd0, 32'h0);
        step(2'd0, 4'd0, 32'h0);
        chk("R4 header held", outs(), 64'd0);
        tx_push = 1'b1; tx_word = 32'hE0E0_0005;
        step(2'd0, 4'd0, 32'h0);
        chk("R4 header held until push lands", outs(), 64'd0);
        step(2'd0, 4'd0, 32'h0);
        chk("R2 header len 2", outs(), 64'({2'd1, 4'd2, hdr(ID, 1, 2)}));
        step(2'd0, 4'd0, 32'h0);
        chk("R3 word D", outs(), 64'({2'd1, 4'd2, 32'hD0D0_0004}));
        step(2'd0, 4'd0, 32'h0);
        chk("R3 word E", outs(), 64'({2'd1, 4'd2, 32'hE0E0_0005}));

        // R5 receive two-word message
        step(2'd1, 4'(ID), hdr(7, 1, 2));
        chk("R5 header freed", outs(), 64'd0);
        step(2'd1, 4'(ID), 32'h1111_0001);
        chk("R5 body freed", outs(), 64'd0);
        step(2'd1, 4'(ID), 32'h1111_0002);
        chk("R5 body freed", outs(), 64'd0);
        chk("R8 not empty", 64'(rx_empty), 64'd0);
        chk("R5 head is header", 64'(rx_word), 64'(hdr(7, 1, 2)));
        rx_pop = 1'b1; step(2'd0, 4'd0, 32'h0);
        chk("R5 order word 1", 64'(rx_word), 64'h1111_0001);
        rx_pop = 1'b1; step(2'd0, 4'd0, 32'h0);
        chk("R5 order word 2", 64'(rx_word), 64'h1111_0002);
        rx_pop = 1'b1; step(2'd0, 4'd0, 32'h0);
        chk("R8 empty after pops", 64'(rx_empty), 64'd1);
        rx_pop = 1'b1; step(2'd0, 4'd0, 32'h0);
        chk("R8 pop on empty", 64'(rx_empty), 64'd1);

        // R6 zero-length message
        step(2'd1, 4'(ID), hdr(7, 1, 0));
        chk("R6 dbg_valid", 64'(dbg_valid), 64'd1);
        chk("R6 dbg_word", 64'(dbg_word), 64'(hdr(7, 1, 0)));
        chk("R6 slot freed", outs(), 64'd0);
        chk("R6 fifo untouched", 64'(rx_empty), 64'd1);
        step(2'd0, 4'd0, 32'h0);
        chk("R6 one-cycle pulse", 64'(dbg_valid), 64'd0);

        // R7 exact fit then overflow
        step(2'd1, 4'(ID), hdr(3, 2, 7));
        chk("R7 exact fit accepted", outs(), 64'd0);
        for (int i = 0; i < 7; i++) begin
            step(2'd1, 4'(ID), 32'h100 + 32'(i));
            chk("R7 exact fit body freed", outs(), 64'd0);
        end
        step(2'd1, 4'(ID), hdr(3, 2, 1));
        chk("R7 header forwarded when full", outs(), 64'({2'd1, 4'(ID), hdr(3, 2, 1)}));
        step(2'd1, 4'(ID), 32'h999);
        chk("R7 body forwarded when full", outs(), 64'({2'd1, 4'(ID), 32'h999}));
        chk("R7 head unchanged", 64'(rx_word), 64'(hdr(3, 2, 7)));
        rx_pop = 1'b1; step(2'd0, 4'd0, 32'h0);
        for (int i = 0; i < 7; i++) begin
            chk("R8 drain order", 64'(rx_word), 64'h100 + 64'(i));
            rx_pop = 1'b1; step(2'd0, 4'd0, 32'h0);
        end
        chk("R8 empty after drain", 64'(rx_empty), 64'd1);
        step(2'd1, 4'(ID), hdr(3, 2, 1));
        step(2'd1, 4'(ID), 32'h999);
        chk("R7 retry accepted", outs(), 64'd0);
        chk("R5 retry head", 64'(rx_word), 64'(hdr(3, 2, 1)));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule